// File: doc/BRIEF.md
# Decode Path Selector

This block picks one decode path each decode clock for a variable-length instruction stream. It looks at already-classified descriptors for the two instructions at the head of a byte buffer. It chooses one of three mutually exclusive paths: a short path that can take two small instructions at once, a long path that takes one instruction, or a vector path for complex work. It reports how many instructions the chosen path consumes and how many bytes the buffer front should move.

Each descriptor carries a byte length, a frequency class, a floating-point escape flag, a multimedia flag and a serializing flag. A separate event input reports a pending interrupt or exception, and it takes precedence over every instruction-based choice. The block has no opcode parsing and generates no operations. Its result is registered, so the path, count and advance for a decode clock appear one clock after that clock's inputs are sampled.

Top module: `dsel_top`

## Requirements
- R1: While reset is held and in the first cycle after it, the path output is IDLE (code 0), the consumed count is 0 and the advance is 0.
- R2: With decode enabled and the event input high, the next result is path VECTOR (code 3) with 0 consumed and advance 0, whatever the descriptors and buffer fill are.
- R3: With decode enabled, no event, and a buffer byte count smaller than the head length, the next result is IDLE with 0 consumed and advance 0.
- R4: A head that is complex (class code 2 or 3), or serializing, or common and longer than 11 bytes, or semi-common (class code 1) and longer than 7 bytes, gives VECTOR with 1 consumed and the head length as advance.
- R5: A non-serializing head that is either common (class code 0) with length 8 to 11 or semi-common with length up to 7 gives path LONG (code 2) with 1 consumed and the head length as advance.
- R6: A non-serializing common head of at most 7 bytes, followed by a non-serializing common second instruction of at most 7 bytes with neither the escape nor the multimedia flag, gives path SHORT (code 1) with 2 consumed and the summed length as advance, provided the buffer holds both.
- R7: When the head qualifies for SHORT but the second does not (escape flag, multimedia flag, serializing, not common, longer than 7 bytes, or not fully in the buffer), the result is SHORT with 1 consumed and the head length as advance.
- R8: The escape flag and the multimedia flag on the head do not prevent a short decode; such a head still pairs with a qualifying second instruction.
- R9: With decode disabled, the next result is IDLE with 0 consumed and advance 0.
- R10: A consumed count of 2 appears only together with path SHORT, and the advance never exceeds the buffer byte count sampled in the same decode clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Decode clock enable |
| event_pend | input | 1 | Pending interrupt or exception |
| buf_bytes | input | AVAIL_W | Valid bytes in the instruction buffer |
| h_len | input | LEN_W | Head instruction length in bytes |
| h_class | input | 2 | Head class: 0 common, 1 semi-common, 2/3 complex |
| h_fpesc | input | 1 | Head is a floating-point escape |
| h_mm | input | 1 | Head is a multimedia instruction |
| h_serial | input | 1 | Head is serializing |
| n_len | input | LEN_W | Second instruction length in bytes |
| n_class | input | 2 | Second instruction class |
| n_fpesc | input | 1 | Second is a floating-point escape |
| n_mm | input | 1 | Second is a multimedia instruction |
| n_serial | input | 1 | Second is serializing |
| path_o | output | 2 | Chosen path: 0 idle, 1 short, 2 long, 3 vector |
| taken_o | output | 2 | Instructions consumed (0, 1 or 2) |
| adv_o | output | LEN_W+1 | Buffer advance in bytes |

## Verification
Two things can land in the same decode clock. A pending event can arrive while the buffer cannot cover the head, and a short-decodable head can arrive with a second instruction that fails on its own flags or on the bytes left in the buffer. The bench sets up both overlaps on purpose: an event with an empty buffer must still yield VECTOR with zero consumed, and a qualifying head with an escape, multimedia or truncated second instruction must give a single-instruction short decode. Each result is compared, one clock later, against an independent model that the driver queues with every stimulus.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

   typedef enum logic [1:0] {
      PATH_IDLE   = 2'd0,
      PATH_SHORT  = 2'd1,
      PATH_LONG   = 2'd2,
      PATH_VECTOR = 2'd3
   } dsel_path_e;

   typedef enum logic [1:0] {
      CLS_COMMON  = 2'd0,
      CLS_SEMI    = 2'd1,
      CLS_COMPLEX = 2'd2,
      CLS_RSVD    = 2'd3
   } dsel_class_e;

   function automatic logic is_complex(input logic [1:0] cls);
      return cls[1];
   endfunction

endpackage

// File: rtl/dsel_slot_eval.sv
module dsel_slot_eval
   import dsel_pkg::*;
#(
   parameter int LEN_W     = 4,
   parameter int SHORT_MAX = 7,
   parameter int LONG_MAX  = 11,
   parameter int SLOT      = 0
) (
   input  logic [LEN_W-1:0] len,
   input  logic [1:0]       cls,
   input  logic             fpesc,
   input  logic             mm,
   input  logic             serial,
   output logic             want_vec,
   output logic             want_long,
   output logic             short_ok
);
   localparam logic [LEN_W-1:0] SMAX = LEN_W'(SHORT_MAX);
   localparam logic [LEN_W-1:0] LMAX = LEN_W'(LONG_MAX);

   logic common_c, semi_c, small_c, medium_c, big_c, base_short;

   assign common_c = (cls == CLS_COMMON);
   assign semi_c   = (cls == CLS_SEMI);
   assign small_c  = (len <= SMAX);
   assign big_c    = (len > LMAX);
   assign medium_c = !small_c && !big_c;

   // anything no hardware path can take is sent to the vector path
   assign want_vec = is_complex(cls) || serial
                     || (common_c && big_c)
                     || (semi_c && !small_c);

   assign want_long  = !want_vec && ((common_c && medium_c) || semi_c);
   assign base_short = !want_vec && common_c && small_c;

   generate
      if (SLOT == 0) begin : g_first
         // the first short slot takes escape and multimedia instructions
         assign short_ok = base_short;
      end else begin : g_second
         // the second slot refuses both
         assign short_ok = base_short && !fpesc && !mm;
      end
   endgenerate

endmodule

// File: rtl/dsel_byte_gate.sv
module dsel_byte_gate #(
   parameter int LEN_W   = 4,
   parameter int AVAIL_W = 5
) (
   input  logic [AVAIL_W-1:0] avail,
   input  logic [LEN_W-1:0]   len0,
   input  logic [LEN_W-1:0]   len1,
   output logic               fit_head,
   output logic               fit_pair,
   output logic [LEN_W:0]     sum_pair
);
   localparam int SUM_W = LEN_W + 1;
   localparam int CW    = (AVAIL_W > SUM_W) ? AVAIL_W : SUM_W;

   logic [CW-1:0] avail_x, head_x, pair_x;

   assign sum_pair = SUM_W'(len0) + SUM_W'(len1);
   assign avail_x  = CW'(avail);
   assign head_x   = CW'(len0);
   assign pair_x   = CW'(sum_pair);
   assign fit_head = (head_x <= avail_x);
   assign fit_pair = (pair_x <= avail_x);

endmodule

// File: rtl/dsel_path_pick.sv
module dsel_path_pick
   import dsel_pkg::*;
#(
   parameter int LEN_W = 4
) (
   input  logic             en,
   input  logic             evt,
   input  logic             fit_head,
   input  logic             fit_pair,
   input  logic [LEN_W-1:0] len0,
   input  logic [LEN_W:0]   sum_pair,
   input  logic             vec0,
   input  logic             long0,
   input  logic             short0,
   input  logic             short1,
   output dsel_path_e       path,
   output logic [1:0]       taken,
   output logic [LEN_W:0]   adv
);
   always_comb begin
      path  = PATH_IDLE;
      taken = 2'd0;
      adv   = '0;
      if (!en) begin
         path = PATH_IDLE;
      end else if (evt) begin
         // events preempt every instruction and consume none of them
         path = PATH_VECTOR;
      end else if (!fit_head) begin
         path = PATH_IDLE;
      end else if (vec0) begin
         path  = PATH_VECTOR;
         taken = 2'd1;
         adv   = (LEN_W+1)'(len0);
      end else if (long0) begin
         path  = PATH_LONG;
         taken = 2'd1;
         adv   = (LEN_W+1)'(len0);
      end else if (short0) begin
         path = PATH_SHORT;
         if (short1 && fit_pair) begin
            taken = 2'd2;
            adv   = sum_pair;
         end else begin
            taken = 2'd1;
            adv   = (LEN_W+1)'(len0);
         end
      end
   end
endmodule

// File: rtl/dsel_top.sv
module dsel_top
   import dsel_pkg::*;
#(
   parameter int LEN_W     = 4,
   parameter int AVAIL_W   = 5,
   parameter int SHORT_MAX = 7,
   parameter int LONG_MAX  = 11,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dec_en,
   input  logic               event_pend,
   input  logic [AVAIL_W-1:0] buf_bytes,
   input  logic [LEN_W-1:0]   h_len,
   input  logic [1:0]         h_class,
   input  logic               h_fpesc,
   input  logic               h_mm,
   input  logic               h_serial,
   input  logic [LEN_W-1:0]   n_len,
   input  logic [1:0]         n_class,
   input  logic               n_fpesc,
   input  logic               n_mm,
   input  logic               n_serial,
   output logic [1:0]         path_o,
   output logic [1:0]         taken_o,
   output logic [LEN_W:0]     adv_o
);
   localparam int ADV_W = LEN_W + 1;

   generate
      if (SHORT_MAX < 1 || SHORT_MAX >= LONG_MAX) begin : g_bad_short
         $error("dsel_top: SHORT_MAX must be at least 1 and below LONG_MAX");
      end
      if (LONG_MAX >= (1 << LEN_W)) begin : g_bad_long
         $error("dsel_top: LONG_MAX must fit in LEN_W bits");
      end
      if (AVAIL_W < LEN_W) begin : g_bad_avail
         $error("dsel_top: AVAIL_W must be at least LEN_W");
      end
   endgenerate

   logic [1:0]       s_vec, s_long, s_short;
   logic             fit_head, fit_pair;
   logic [ADV_W-1:0] sum_pair, adv_c;
   logic [1:0]       taken_c;
   dsel_path_e       path_c;

   logic [LEN_W-1:0] len_a   [2];
   logic [1:0]       cls_a   [2];
   logic [1:0]       fp_a, mm_a, ser_a;

   assign len_a[0] = h_len;   assign len_a[1] = n_len;
   assign cls_a[0] = h_class; assign cls_a[1] = n_class;
   assign fp_a     = {n_fpesc, h_fpesc};
   assign mm_a     = {n_mm, h_mm};
   assign ser_a    = {n_serial, h_serial};

   for (genvar s = 0; s < 2; s++) begin : g_slot
      dsel_slot_eval #(
         .LEN_W(LEN_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX), .SLOT(s)
      ) i_eval (
         .len(len_a[s]), .cls(cls_a[s]), .fpesc(fp_a[s]), .mm(mm_a[s]),
         .serial(ser_a[s]), .want_vec(s_vec[s]), .want_long(s_long[s]),
         .short_ok(s_short[s])
      );
   end

   dsel_byte_gate #(.LEN_W(LEN_W), .AVAIL_W(AVAIL_W)) i_gate (
      .avail(buf_bytes), .len0(h_len), .len1(n_len),
      .fit_head(fit_head), .fit_pair(fit_pair), .sum_pair(sum_pair)
   );

   dsel_path_pick #(.LEN_W(LEN_W)) i_pick (
      .en(dec_en), .evt(event_pend), .fit_head(fit_head), .fit_pair(fit_pair),
      .len0(h_len), .sum_pair(sum_pair), .vec0(s_vec[0]), .long0(s_long[0]),
      .short0(s_short[0]), .short1(s_short[1]),
      .path(path_c), .taken(taken_c), .adv(adv_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               path_o  <= PATH_IDLE;
               taken_o <= 2'd0;
               adv_o   <= '0;
            end else begin
               path_o  <= path_c;
               taken_o <= taken_c;
               adv_o   <= adv_c;
            end
         end

         p_event_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en && event_pend) |=> (path_o == PATH_VECTOR && taken_o == 2'd0 && adv_o == '0));

         p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_en |=> (path_o == PATH_IDLE && taken_o == 2'd0));

         p_pair_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (taken_o == 2'd2) |-> (path_o == PATH_SHORT));

         p_adv_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
            dec_en |=> (32'(adv_o) <= 32'($past(buf_bytes))));

         p_no_fp_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en && n_fpesc) |=> (taken_o != 2'd2));

         p_no_mm_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en && n_mm) |=> (taken_o != 2'd2));

         p_short_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_en && !event_pend && fit_head && h_class == CLS_COMMON && !h_serial
             && 32'(h_len) <= SHORT_MAX) |=> (path_o == PATH_SHORT));
      end else begin : g_comb
         assign path_o  = path_c;
         assign taken_o = taken_c;
         assign adv_o   = adv_c;
      end
   endgenerate

endmodule

// File: tb/test_dsel_top.sv
module test_dsel_top;
   localparam int LEN_W = 4;
   localparam int AVAIL_W = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic dec_en = 1'b0, event_pend = 1'b0;
   logic [AVAIL_W-1:0] buf_bytes = '0;
   logic [LEN_W-1:0] h_len = '0, n_len = '0;
   logic [1:0] h_class = '0, n_class = '0;
   logic h_fpesc = 0, h_mm = 0, h_serial = 0, n_fpesc = 0, n_mm = 0, n_serial = 0;
   logic [1:0] path_o, taken_o;
   logic [LEN_W:0] adv_o;

   always #5 clk = ~clk;

   dsel_top i_dsel_top (
      .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .event_pend(event_pend),
      .buf_bytes(buf_bytes), .h_len(h_len), .h_class(h_class), .h_fpesc(h_fpesc),
      .h_mm(h_mm), .h_serial(h_serial), .n_len(n_len), .n_class(n_class),
      .n_fpesc(n_fpesc), .n_mm(n_mm), .n_serial(n_serial),
      .path_o(path_o), .taken_o(taken_o), .adv_o(adv_o)
   );

   typedef struct {
      int    p;
      int    t;
      int    a;
      string tag;
   } exp_t;

   exp_t sb[$];
   int n_run = 0, n_fail = 0;
   bit done = 0;

   task automatic check(input string tag, input int ap, at, aa, ep, et, ea);
      n_run++;
      if (ap != ep || at != et || aa != ea) begin
         n_fail++;
         $display("FAIL %s: path/taken/adv got %0d/%0d/%0d expected %0d/%0d/%0d",
                  tag, ap, at, aa, ep, et, ea);
      end
   endtask

   // reference model written from the requirements
   function automatic exp_t model(input bit en, ev, input int avail,
                                  input int l0, c0, input bit f0, m0, s0,
                                  input int l1, c1, input bit f1, m1, s1);
      exp_t e;
      bit sh0, sh1;
      e.p = 0; e.t = 0; e.a = 0; e.tag = "";
      if (!en) return e;
      if (ev) begin e.p = 3; return e; end
      if (l0 > avail) return e;
      if (c0 >= 2 || s0 || (c0 == 0 && l0 > 11) || (c0 == 1 && l0 > 7)) begin
         e.p = 3; e.t = 1; e.a = l0; return e;
      end
      if ((c0 == 0 && l0 >= 8) || c0 == 1) begin
         e.p = 2; e.t = 1; e.a = l0; return e;
      end
      sh0 = 1;
      sh1 = (c1 == 0) && !s1 && l1 <= 7 && !f1 && !m1 && (l0 + l1 <= avail);
      e.p = 1;
      if (sh0 && sh1) begin e.t = 2; e.a = l0 + l1; end
      else begin e.t = 1; e.a = l0; end
      return e;
   endfunction

   task automatic drive(input string tag, input bit en, ev, input int avail,
                        input int l0, c0, input bit f0, m0, s0,
                        input int l1, c1, input bit f1, m1, s1);
      exp_t e;
      @(negedge clk);
      dec_en = en; event_pend = ev; buf_bytes = AVAIL_W'(avail);
      h_len = LEN_W'(l0); h_class = 2'(c0); h_fpesc = f0; h_mm = m0; h_serial = s0;
      n_len = LEN_W'(l1); n_class = 2'(c1); n_fpesc = f1; n_mm = m1; n_serial = s1;
      e = model(en, ev, avail, l0, c0, f0, m0, s0, l1, c1, f1, m1, s1);
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: results appear one clock after the sampled inputs
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, int'(path_o), int'(taken_o), int'(adv_o), e.p, e.t, e.a);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: run hung, got 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 in reset", int'(path_o), int'(taken_o), int'(adv_o), 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check("R1 after reset", int'(path_o), int'(taken_o), int'(adv_o), 0, 0, 0);

      drive("R9 disabled",          0,0,20, 3,0,0,0,0, 3,0,0,0,0);
      drive("R2 event complex",     1,1,20, 5,2,0,0,0, 3,0,0,0,0);
      drive("R2 event empty buf",   1,1, 0, 9,0,0,0,0, 3,0,0,0,0);
      drive("R3 short buffer",      1,0, 3, 5,0,0,0,0, 2,0,0,0,0);
      drive("R4 complex head",      1,0,20, 4,2,0,0,0, 2,0,0,0,0);
      drive("R4 class3 head",       1,0,20, 2,3,0,0,0, 2,0,0,0,0);
      drive("R4 serial head",       1,0,20, 3,0,0,0,1, 2,0,0,0,0);
      drive("R4 common len12",      1,0,20,12,0,0,0,0, 2,0,0,0,0);
      drive("R4 semi len9",         1,0,20, 9,1,0,0,0, 2,0,0,0,0);
      drive("R5 common len8",       1,0,20, 8,0,0,0,0, 2,0,0,0,0);
      drive("R5 common len11",      1,0,11,11,0,0,0,0, 2,0,0,0,0);
      drive("R5 semi len3",         1,0,20, 3,1,0,0,0, 2,0,0,0,0);
      drive("R6 pair 3+4",          1,0, 7, 3,0,0,0,0, 4,0,0,0,0);
      drive("R6 pair 7+7",          1,0,14, 7,0,0,0,0, 7,0,0,0,0);
      drive("R7 pair truncated",    1,0, 6, 3,0,0,0,0, 4,0,0,0,0);
      drive("R7 second escape",     1,0,20, 3,0,0,0,0, 2,0,1,0,0);
      drive("R7 second mm",         1,0,20, 3,0,0,0,0, 2,0,0,1,0);
      drive("R7 second long",       1,0,20, 3,0,0,0,0, 8,0,0,0,0);
      drive("R7 second semi",       1,0,20, 3,0,0,0,0, 2,1,0,0,0);
      drive("R7 second serial",     1,0,20, 3,0,0,0,0, 2,0,0,0,1);
      drive("R8 head escape pairs", 1,0,20, 4,0,1,0,0, 2,0,0,0,0);
      drive("R8 head mm pairs",     1,0,20, 6,0,0,1,0, 5,0,0,0,0);
      drive("R8 head esc+mm both",  1,0,20, 5,0,1,1,0, 3,0,1,1,0);

      // mixed stream: path exclusivity and byte bound, R10
      for (int i = 0; i < 400; i++) begin
         int c0, c1, l0, l1;
         c0 = int'($urandom_range(0, 3));
         c1 = int'($urandom_range(0, 3));
         l0 = int'($urandom_range(1, 15));
         l1 = int'($urandom_range(1, 15));
         drive("R10 mixed", ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) == 0),
               int'($urandom_range(0, 31)), l0, c0, ($urandom_range(0, 3) == 0),
               ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0),
               l1, c1, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
               ($urandom_range(0, 7) == 0));
      end

      @(negedge clk);
      dec_en = 1'b0;
      repeat (4) @(posedge clk);
      #3;
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule